// File: doc/BRIEF.md
# Pipelined Key-Expansion Mixing Stage

This block is one iteration of an add-rotate key-expansion schedule, built for a brute-force key-search datapath where a fresh candidate key enters on every clock. Each incoming key context carries two running words A and B, a key word L and a table word S. The stage forms A+B once and uses it twice. The new table word is S+A+B rotated left by a fixed amount, which is only wiring. The new key word is L+A+B rotated left by a data-dependent amount taken from the low bits of A+B. The new table word also serves as the next iteration's A, and the new key word serves as its B, so a chain of these stages forms one round of the schedule.

A later round needs, at the same stage position, the table word that this stage produced a whole round earlier. The stage keeps that value in a delay line of DEPTH entries, 26 in a full schedule. Each accepted key pushes its new table word in and takes out the word pushed DEPTH accepted keys before. The delay line has two storage variants with identical behaviour, picked by a parameter: a shift register, or a ring buffer with one pointer.

Both sides of the stage are valid/ready streams. A key is taken when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high whenever the output register is empty or is being emptied in that cycle, so an unstalled stream takes one key per clock. While `out_valid` is high and `out_ready` is low, the output holds and no key is taken.

Top module: `kx_stage`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1, and the delay line holds zeros.
- R2: For an accepted key, `out_s` = (in_s + in_a + in_b) rotated left by FIXED_ROT (3 by default), modulo 2^W.
- R3: For an accepted key, `out_l` = (in_l + in_a + in_b) rotated left by n, where n is bits [log2(W)-1:0] of (in_a + in_b). This covers every n from 0 to W-1, including 0 (no rotate) and W-1.
- R4: For the k-th accepted key (counting from 0), `out_s_late` equals the `out_s` value of accepted key k-DEPTH, or 0 when k < DEPTH.
- R5: Results appear on the outputs one clock after the key is accepted, with `out_valid` high. With `out_ready` held high, one key is accepted every clock.
- R6: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_s`, `out_l`, `out_s_late` and `out_valid` hold their values.
- R7: The delay line advances only when a key is accepted. Idle cycles and stalled cycles do not shift it.
- R8: The shift-register and ring-buffer variants of the delay line give identical port behaviour.
- R9: When the output is taken (`out_valid` and `out_ready` both 1) and no key is accepted, `out_valid` is 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Key context on the input is valid |
| in_ready | output | 1 | Stage can take a key this cycle |
| in_a | input | W | Running word A |
| in_b | input | W | Running word B |
| in_s | input | W | Table word S |
| in_l | input | W | Key word L |
| out_valid | output | 1 | Output holds a result |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_s | output | W | New table word, also the next A |
| out_l | output | W | New key word, also the next B |
| out_s_late | output | W | Table word produced DEPTH accepted keys earlier |

## Verification
The bench builds two instances at W=32 side by side on the same streams: a shift-register delay line with DEPTH=3 and a ring-buffer delay line with DEPTH=5. The short depths let the delay line fill and wrap many times within a few hundred keys, so both variants can be compared against one arithmetic model. A sweep sets every rotate amount from 0 to 31 with several operand patterns. A random phase with bubbles and back-pressure then checks that stalls and idle cycles leave the late-S sequence unshifted.

// File: rtl/kx_pkg.sv
package kx_pkg;
  // Storage variant of the round-to-round delay line.
  typedef enum logic [0:0] {
    KX_SHIFT = 1'b0,
    KX_RING  = 1'b1
  } kx_dly_e;
endpackage

// File: rtl/kx_rotl.sv
module kx_rotl #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   i_d,
  input  logic [SHW-1:0] i_amt,
  output logic [W-1:0]   o_d
);
  // Logarithmic barrel: stage k rotates by 2^k when amount bit k is set.
  logic [W-1:0] st [SHW+1];

  assign st[0] = i_d;

  for (genvar k = 0; k < SHW; k++) begin : g_lvl
    localparam int SH = 1 << k;
    assign st[k+1] = i_amt[k] ? {st[k][W-1-SH:0], st[k][W-1:W-SH]} : st[k];
  end

  assign o_d = st[SHW];
endmodule

// File: rtl/kx_mix.sv
module kx_mix #(
  parameter int W         = 32,
  parameter int FIXED_ROT = 3
) (
  input  logic [W-1:0] i_a,
  input  logic [W-1:0] i_b,
  input  logic [W-1:0] i_s,
  input  logic [W-1:0] i_l,
  output logic [W-1:0] o_s,
  output logic [W-1:0] o_l
);
  localparam int SHW = $clog2(W);

  logic [W-1:0] sum_ab;
  logic [W-1:0] pre_s;
  logic [W-1:0] pre_l;

  // The shared A+B feeds both sums and supplies the variable rotate amount.
  assign sum_ab = i_a + i_b;
  assign pre_s  = i_s + sum_ab;
  assign pre_l  = i_l + sum_ab;

  // Fixed rotate: pure rewiring.
  assign o_s = {pre_s[W-1-FIXED_ROT:0], pre_s[W-1:W-FIXED_ROT]};

  kx_rotl #(.W(W), .SHW(SHW)) u_rot (
    .i_d  (pre_l),
    .i_amt(sum_ab[SHW-1:0]),
    .o_d  (o_l)
  );

  // R2 / R3: a rotate moves bits without creating or dropping any.
  always_comb begin
    if (!$isunknown(pre_s)) begin
      a_r2_fixed_keeps_bits: assert ($countones(o_s) == $countones(pre_s));
    end
    if (!$isunknown(pre_l)) begin
      a_r3_var_keeps_bits: assert ($countones(o_l) == $countones(pre_l));
    end
  end
endmodule

// File: rtl/kx_sdelay.sv
module kx_sdelay #(
  parameter int              W     = 32,
  parameter int              DEPTH = 26,
  parameter kx_pkg::kx_dly_e STYLE = kx_pkg::KX_SHIFT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         i_push,
  input  logic [W-1:0] i_d,
  output logic [W-1:0] o_oldest
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  if (STYLE == kx_pkg::KX_SHIFT) begin : g_shift
    // Entry 0 is the newest word, entry DEPTH-1 the oldest.
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (i_push) begin
        mem[0] <= i_d;
        for (int i = 1; i < DEPTH; i++) mem[i] <= mem[i-1];
      end
    end

    assign o_oldest = mem[DEPTH-1];
  end else begin : g_ring
    // One pointer: the slot read as oldest is the slot overwritten by the push.
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] ptr;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        ptr <= '0;
      end else if (i_push) begin
        mem[ptr] <= i_d;
        ptr      <= (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
      end
    end

    assign o_oldest = mem[ptr];

    // R4: the pointer wraps before leaving the DEPTH slots.
    a_r4_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= PW'(DEPTH - 1));
  end

  // R7: without a push the oldest word does not move.
  a_r7_no_push_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !i_push |=> $stable(o_oldest));
endmodule

// File: rtl/kx_stage.sv
module kx_stage #(
  parameter int              W         = 32,
  parameter int              DEPTH     = 26,
  parameter int              FIXED_ROT = 3,
  parameter kx_pkg::kx_dly_e DLY_STYLE = kx_pkg::KX_SHIFT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_s,
  input  logic [W-1:0] in_l,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_s,
  output logic [W-1:0] out_l,
  output logic [W-1:0] out_s_late
);
  logic         accept;
  logic [W-1:0] nxt_s;
  logic [W-1:0] nxt_l;
  logic [W-1:0] oldest_s;

  // Output register is free when empty or being drained this cycle.
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  kx_mix #(.W(W), .FIXED_ROT(FIXED_ROT)) u_mix (
    .i_a(in_a),
    .i_b(in_b),
    .i_s(in_s),
    .i_l(in_l),
    .o_s(nxt_s),
    .o_l(nxt_l)
  );

  kx_sdelay #(.W(W), .DEPTH(DEPTH), .STYLE(DLY_STYLE)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .i_push  (accept),
    .i_d     (nxt_s),
    .o_oldest(oldest_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_s      <= '0;
      out_l      <= '0;
      out_s_late <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_s      <= nxt_s;
      out_l      <= nxt_l;
      out_s_late <= oldest_s;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R6: a stalled output holds and blocks the input.
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_s) &&
                                   $stable(out_l) && $stable(out_s_late)));

  a_r6_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R5: an accepted key shows up one clock later.
  a_r5_one_clock_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9: a drained output with no new key empties.
  a_r9_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: tb/test_kx_stage.sv
module test_kx_stage;
  localparam int W  = 32;
  localparam int D0 = 3;
  localparam int D1 = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0, in_s = '0, in_l = '0;

  logic         rdy0, ov0, rdy1, ov1;
  logic [W-1:0] s0, l0, late0, s1, l1, late1;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  kx_stage #(.W(W), .DEPTH(D0), .DLY_STYLE(kx_pkg::KX_SHIFT)) i_kx_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy0),
    .in_a(in_a), .in_b(in_b), .in_s(in_s), .in_l(in_l),
    .out_valid(ov0), .out_ready(out_ready),
    .out_s(s0), .out_l(l0), .out_s_late(late0)
  );

  kx_stage #(.W(W), .DEPTH(D1), .DLY_STYLE(kx_pkg::KX_RING)) i_kx_stage_ring (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy1),
    .in_a(in_a), .in_b(in_b), .in_s(in_s), .in_l(in_l),
    .out_valid(ov1), .out_ready(out_ready),
    .out_s(s1), .out_l(l1), .out_s_late(late1)
  );

  // Bench model state
  logic         exp_ov = 1'b0;
  logic [W-1:0] exp_s = '0, exp_l = '0, exp_late0 = '0, exp_late1 = '0;
  logic [W-1:0] hist [$];

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int n);
    logic [2*W-1:0] t;
    t = {x, x} << n;
    return t[2*W-1:W];
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // One cycle: check outputs at the falling edge, drive new inputs, step model.
  task automatic cycle(input bit v, input bit ordy, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [W-1:0] s,
                       input logic [W-1:0] l);
    bit acc;
    logic [W-1:0] ab;
    @(negedge clk);
    chk("R5 R9 out_valid shift", W'(ov0), W'(exp_ov));
    chk("R8 out_valid ring", W'(ov1), W'(exp_ov));
    if (exp_ov) begin
      chk("R2 out_s shift", s0, exp_s);
      chk("R3 out_l shift", l0, exp_l);
      chk("R4 R7 out_s_late shift", late0, exp_late0);
      chk("R8 R2 out_s ring", s1, exp_s);
      chk("R8 R3 out_l ring", l1, exp_l);
      chk("R8 R4 R7 out_s_late ring", late1, exp_late1);
    end
    in_valid = v; out_ready = ordy;
    in_a = a; in_b = b; in_s = s; in_l = l;
    #1;
    chk("R6 in_ready shift", W'(rdy0), W'(!exp_ov || ordy));
    chk("R8 R6 in_ready ring", W'(rdy1), W'(!exp_ov || ordy));
    acc = v && (!exp_ov || ordy);
    if (acc) begin
      ab        = a + b;
      exp_s     = rotl(s + ab, 3);
      exp_l     = rotl(l + ab, int'(ab[4:0]));
      exp_late0 = (hist.size() >= D0) ? hist[hist.size() - D0] : '0;
      exp_late1 = (hist.size() >= D1) ? hist[hist.size() - D1] : '0;
      hist.push_back(exp_s);
      exp_ov    = 1'b1;
    end else if (ordy) begin
      exp_ov    = 1'b0;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] a, b, tgt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 out_valid after reset", W'(ov0), '0);
    chk("R1 in_ready after reset", W'(rdy0), W'(1));
    chk("R1 ring in_ready after reset", W'(rdy1), W'(1));

    // R3: sweep every rotate amount with several operand patterns, full rate (R5)
    for (int amt = 0; amt < 32; amt++) begin
      for (int p = 0; p < 4; p++) begin
        a   = (p == 0) ? '0 : (p == 1) ? '1 : $urandom;
        tgt = {$urandom, 5'(amt)} ;
        b   = tgt - a;
        cycle(1'b1, 1'b1, a, b, (p == 2) ? '1 : $urandom, (p == 3) ? 32'h1 : $urandom);
      end
    end

    // R9: drain to empty, then idle cycles must not shift the delay line (R7)
    cycle(1'b0, 1'b1, '0, '0, '0, '0);
    repeat (3) cycle(1'b0, 1'b1, $urandom, $urandom, $urandom, $urandom);

    // R6: stall with a pending key, then release
    cycle(1'b1, 1'b1, $urandom, $urandom, $urandom, $urandom);
    repeat (4) cycle(1'b1, 1'b0, $urandom, $urandom, $urandom, $urandom);
    cycle(1'b1, 1'b1, 32'h7, 32'h18, $urandom, $urandom);  // A+B low bits = 31

    // Random bubbles and back-pressure
    for (int n = 0; n < 500; n++) begin
      cycle(($urandom % 10) < 7, ($urandom % 10) < 6,
            $urandom, $urandom, $urandom, $urandom);
    end

    repeat (3) cycle(1'b0, 1'b1, '0, '0, '0, '0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule